// File: doc/BRIEF.md
# Owner-Locked Event Notification Controller

This block is the device-side register unit that tells one remote owner about device events. It keeps a 64-bit owner address: a 16-bit node identifier in bits 63:48 and an offset in bits 47:0. The owner can only be claimed or released with an atomic compare-and-swap request, and a bus reset forces it back to the no-owner value `0xFFFF_0000_0000_0000`. A bus reset also clears the streaming-enable flag. Ordinary register writes cannot change the owner.

Event pulses from the rest of the device arrive on a vector. In any cycle where that vector is non-zero, the readable notification word is overwritten with exactly those bits. The same bits are also pushed to the owner as an outbound write request. The push uses a valid/ready stream. The producer raises `ntf_valid_o` and holds the address and data until `ntf_ready_i` is sampled high. While a request waits, new events are ORed into a pending word. That word goes out in the cycle after the acknowledge. No request is raised while nobody owns the device.

The compare-and-swap port is also valid/ready. `cas_ready_o` is low during a bus reset, so a request in that cycle is not taken, and the requester must hold it.

Top module: `evnotify_ctrl`

## Requirements
- R1: After `rst_n` is released, the owner reads `0xFFFF_0000_0000_0000`, the notification word reads 0, `stream_en_o` is 0, and `ntf_valid_o` and `cas_rsp_valid_o` are 0.
- R2: A compare-and-swap is taken in a cycle where `cas_valid_i` and `cas_ready_o` are both high. In the next cycle `cas_rsp_valid_o` is high and `cas_old_o` holds the owner value from before the swap. The owner becomes `cas_new_i`, and `cas_swapped_o` is 1, only if that old value equals `cas_cmp_i`. Otherwise the owner is unchanged and `cas_swapped_o` is 0.
- R3: Register writes to word 0 (owner high), word 1 (owner low) or word 2 (notification) have no effect. A write to word 3 sets `stream_en_o` to 1 if the written data is non-zero and to 0 if it is zero.
- R4: When `bus_reset_i` is high, the owner is `0xFFFF_0000_0000_0000` and `stream_en_o` is 0 in the next cycle. `cas_ready_o` is low in that same cycle, so a simultaneous compare-and-swap gives no response and has no effect.
- R5: In a cycle where `evt_i` is non-zero, the notification word in the next cycle equals `evt_i` alone. Earlier bits are cleared.
- R6: When no request is outstanding (or one completes this cycle), the owner is not the no-owner value, and the pending word ORed with `evt_i` is non-zero, a request is raised in the next cycle. Its data is that OR and its address is the current owner.
- R7: While the owner equals the no-owner value, no request is raised. Event bits offered for sending in that case are dropped.
- R8: While `ntf_valid_o` is high and `ntf_ready_i` is low, the request stays valid in the next cycle with unchanged `ntf_addr_o` and `ntf_data_o`.
- R9: Events that arrive while a request is stalled are ORed into a pending word. They go out in the request that follows the acknowledge, ORed with any events present in the acknowledge cycle.
- R10: The event bits are: receive-config changed = bit 0, transmit-config changed = bit 1, lock changed = bit 4, clock selection accepted = bit 5, extended status changed = bit 6. The other bits are device-specific. All bits pass to the notification word and the request unaltered.
- R11: `rd_data_o` returns, as a combinational function of `rd_addr_i`:
  - word 0: owner bits 63:32
  - word 1: owner bits 31:0
  - word 2: the notification word
  - word 3: the enable flag in bit 0, with zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | Bus reset; clears owner and enable |
| cas_valid_i | input | 1 | Compare-and-swap request valid |
| cas_ready_o | output | 1 | Compare-and-swap request accepted (low during bus reset) |
| cas_cmp_i | input | 64 | Compare operand |
| cas_new_i | input | 64 | Value stored on a match |
| cas_rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| cas_old_o | output | 64 | Owner value before the operation |
| cas_swapped_o | output | 1 | 1 if the swap took effect |
| wr_en_i | input | 1 | Plain register write strobe |
| wr_addr_i | input | 2 | Plain write word index |
| wr_data_i | input | 32 | Plain write data |
| rd_addr_i | input | 2 | Read word index |
| rd_data_o | output | 32 | Read data |
| stream_en_o | output | 1 | Streaming-enable flag |
| evt_i | input | 32 | Event pulses, one bit per event kind |
| ntf_valid_o | output | 1 | Notification request valid |
| ntf_ready_i | input | 1 | Notification request acknowledge |
| ntf_addr_o | output | 64 | Target address (owner at launch) |
| ntf_data_o | output | 32 | Notification word to send |

## Verification
Two pairs of functions can meet in one cycle:
- A bus reset and a compare-and-swap. The bench asserts both in a directed cycle, with a compare operand that would otherwise match, and also lets them coincide at random. It judges the outcome by the missing response and by reading the owner words afterwards.
- A notification acknowledge and a new event batch. The bench makes them coincide with random ready and sparse random events. It checks that the following request carries the pending bits ORed with the new ones, and that the notification word holds only the newest batch.

// File: rtl/evn_pkg.sv
package evn_pkg;
  localparam int OWN_W   = 64;
  localparam int NODE_SH = 48;
  localparam int WORD_W  = 32;
  localparam int RA_W    = 2;
  localparam logic [OWN_W-1:0] OWNER_NONE = {16'hFFFF, {NODE_SH{1'b0}}};

  // event bit positions
  localparam int EVB_RXCFG  = 0;
  localparam int EVB_TXCFG  = 1;
  localparam int EVB_LOCK   = 4;
  localparam int EVB_CLKACC = 5;
  localparam int EVB_EXTST  = 6;

  typedef enum logic [RA_W-1:0] {
    RA_OWNER_HI = 2'd0,
    RA_OWNER_LO = 2'd1,
    RA_NOTE     = 2'd2,
    RA_ENABLE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/evn_owner_cas.sv
module evn_owner_cas
  import evn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset_i,
  input  logic             cas_fire_i,
  input  logic [OWN_W-1:0] cas_cmp_i,
  input  logic [OWN_W-1:0] cas_new_i,
  output logic [OWN_W-1:0] owner_o,
  output logic             rsp_valid_o,
  output logic [OWN_W-1:0] rsp_old_o,
  output logic             rsp_swapped_o
);
  logic [OWN_W-1:0] owner_q;
  logic             hit;

  assign hit     = (owner_q == cas_cmp_i);
  assign owner_o = owner_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q       <= OWNER_NONE;
      rsp_valid_o   <= 1'b0;
      rsp_old_o     <= '0;
      rsp_swapped_o <= 1'b0;
    end else begin
      rsp_valid_o <= cas_fire_i;
      if (cas_fire_i) begin
        rsp_old_o     <= owner_q;
        rsp_swapped_o <= hit;
      end
      if (bus_reset_i)
        owner_q <= OWNER_NONE;
      else if (cas_fire_i && hit)
        owner_q <= cas_new_i;
    end
  end
endmodule

// File: rtl/evn_regs.sv
module evn_regs
  import evn_pkg::*;
#(
  parameter int EVW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset_i,
  input  logic              wr_en_i,
  input  logic [RA_W-1:0]   wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [WORD_W-1:0] evt_word_i,
  input  logic [OWN_W-1:0]  owner_i,
  input  logic [RA_W-1:0]   rd_addr_i,
  output logic              stream_en_o,
  output logic [WORD_W-1:0] note_o,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] note_q;
  logic              en_q;
  logic              en_wr;

  assign en_wr       = wr_en_i && (reg_addr_e'(wr_addr_i) == RA_ENABLE);
  assign note_o      = note_q;
  assign stream_en_o = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      note_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (|evt_word_i) note_q <= evt_word_i;
      if (bus_reset_i)  en_q <= 1'b0;
      else if (en_wr)   en_q <= |wr_data_i;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(rd_addr_i))
      RA_OWNER_HI: rd_data_o = owner_i[OWN_W-1:WORD_W];
      RA_OWNER_LO: rd_data_o = owner_i[WORD_W-1:0];
      RA_NOTE:     rd_data_o = note_q;
      default:     rd_data_o = {{(WORD_W-1){1'b0}}, en_q};
    endcase
  end
endmodule

// File: rtl/evn_notify_tx.sv
module evn_notify_tx
  import evn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] evt_word_i,
  input  logic [OWN_W-1:0]  owner_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [OWN_W-1:0]  addr_o,
  output logic [WORD_W-1:0] data_o
);
  logic [WORD_W-1:0] pend_q;
  logic [WORD_W-1:0] cand;
  logic              slot_free;
  logic              owner_ok;

  assign slot_free = !valid_o || ready_i;
  assign cand      = pend_q | evt_word_i;
  assign owner_ok  = (owner_i != OWNER_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (slot_free) begin
      pend_q <= '0;
      if ((|cand) && owner_ok) begin
        valid_o <= 1'b1;
        addr_o  <= owner_i;
        data_o  <= cand;
      end else begin
        valid_o <= 1'b0;
      end
    end else begin
      pend_q <= pend_q | evt_word_i;
    end
  end
endmodule

// File: rtl/evnotify_ctrl.sv
module evnotify_ctrl
  import evn_pkg::*;
#(
  parameter int EVW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset_i,
  input  logic              cas_valid_i,
  output logic              cas_ready_o,
  input  logic [63:0]       cas_cmp_i,
  input  logic [63:0]       cas_new_i,
  output logic              cas_rsp_valid_o,
  output logic [63:0]       cas_old_o,
  output logic              cas_swapped_o,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              stream_en_o,
  input  logic [EVW-1:0]    evt_i,
  output logic              ntf_valid_o,
  input  logic              ntf_ready_i,
  output logic [63:0]       ntf_addr_o,
  output logic [31:0]       ntf_data_o
);
  logic [OWN_W-1:0]  owner_w;
  logic [WORD_W-1:0] note_w;
  logic [WORD_W-1:0] evt_word;
  logic              cas_fire;

  generate
    if (EVW < WORD_W) begin : g_pad
      assign evt_word = {{(WORD_W-EVW){1'b0}}, evt_i};
    end else begin : g_full
      assign evt_word = evt_i[WORD_W-1:0];
    end
  endgenerate

  assign cas_ready_o = !bus_reset_i;
  assign cas_fire    = cas_valid_i && cas_ready_o;

  evn_owner_cas u_owner (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_reset_i   (bus_reset_i),
    .cas_fire_i    (cas_fire),
    .cas_cmp_i     (cas_cmp_i),
    .cas_new_i     (cas_new_i),
    .owner_o       (owner_w),
    .rsp_valid_o   (cas_rsp_valid_o),
    .rsp_old_o     (cas_old_o),
    .rsp_swapped_o (cas_swapped_o)
  );

  evn_regs #(.EVW(EVW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_reset_i (bus_reset_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .evt_word_i  (evt_word),
    .owner_i     (owner_w),
    .rd_addr_i   (rd_addr_i),
    .stream_en_o (stream_en_o),
    .note_o      (note_w),
    .rd_data_o   (rd_data_o)
  );

  evn_notify_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_word_i (evt_word),
    .owner_i    (owner_w),
    .ready_i    (ntf_ready_i),
    .valid_o    (ntf_valid_o),
    .addr_o     (ntf_addr_o),
    .data_o     (ntf_data_o)
  );
endmodule

// File: rtl/evnotify_ctrl_chk.sv
module evnotify_ctrl_chk
  import evn_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_reset_i,
  input logic        cas_valid_i,
  input logic        cas_ready_o,
  input logic [63:0] cas_cmp_i,
  input logic [63:0] cas_new_i,
  input logic        cas_rsp_valid_o,
  input logic        stream_en_o,
  input logic [31:0] evt_word,
  input logic        ntf_valid_o,
  input logic        ntf_ready_i,
  input logic [63:0] ntf_addr_o,
  input logic [31:0] ntf_data_o,
  input logic [63:0] owner_w,
  input logic [31:0] note_w
);
  p_cas_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid_i && cas_ready_o |=> cas_rsp_valid_o);
  p_cas_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid_i && cas_ready_o && (owner_w == cas_cmp_i) |=> owner_w == $past(cas_new_i));
  p_busrst_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> (owner_w == OWNER_NONE) && !stream_en_o);
  p_busrst_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i && cas_valid_i |=> !cas_rsp_valid_o);
  p_note_batch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_word) |=> note_w == $past(evt_word));
  p_data_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid_o |-> ntf_data_o != '0);
  p_owned_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid_o |-> ntf_addr_o != OWNER_NONE);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid_o && !ntf_ready_i |=> ntf_valid_o && $stable(ntf_addr_o) && $stable(ntf_data_o));
endmodule

bind evnotify_ctrl evnotify_ctrl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_reset_i     (bus_reset_i),
  .cas_valid_i     (cas_valid_i),
  .cas_ready_o     (cas_ready_o),
  .cas_cmp_i       (cas_cmp_i),
  .cas_new_i       (cas_new_i),
  .cas_rsp_valid_o (cas_rsp_valid_o),
  .stream_en_o     (stream_en_o),
  .evt_word        (evt_word),
  .ntf_valid_o     (ntf_valid_o),
  .ntf_ready_i     (ntf_ready_i),
  .ntf_addr_o      (ntf_addr_o),
  .ntf_data_o      (ntf_data_o),
  .owner_w         (owner_w),
  .note_w          (note_w)
);

// File: tb/evnotify_ctrl_bench.sv
module evnotify_ctrl_bench;
  import evn_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset_i = 1'b0;
  logic        cas_valid_i = 1'b0;
  logic        cas_ready_o;
  logic [63:0] cas_cmp_i = '0, cas_new_i = '0;
  logic        cas_rsp_valid_o;
  logic [63:0] cas_old_o;
  logic        cas_swapped_o;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        stream_en_o;
  logic [31:0] evt_i = '0;
  logic        ntf_valid_o;
  logic        ntf_ready_i = 1'b0;
  logic [63:0] ntf_addr_o;
  logic [31:0] ntf_data_o;

  int checks = 0, errors = 0;

  // reference state
  logic [63:0] m_owner = OWNER_NONE;
  logic        m_en = 1'b0;
  logic [31:0] m_note = '0, m_pend = '0, m_data = '0;
  logic [63:0] m_addr = '0, m_old = '0;
  logic        m_valid = 1'b0, m_rsp = 1'b0, m_sw = 1'b0;

  evnotify_ctrl u_evnotify_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_owner[63:32];
      2'd1: return m_owner[31:0];
      2'd2: return m_note;
      default: return {31'b0, m_en};
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // check registered outputs, drive a cycle of inputs, check combinational reads, advance the model
  task automatic step(input string tag, input bit br, input bit cv, input logic [63:0] cmp,
                      input logic [63:0] nw, input bit we, input logic [1:0] wa,
                      input logic [31:0] wd, input logic [1:0] ra, input logic [31:0] ev,
                      input bit rdy);
    logic        fire, free;
    logic [31:0] cand;
    logic [63:0] own_now;
    @(negedge clk);
    chk(cas_rsp_valid_o == m_rsp, {tag, " R2 rsp_valid"}, 64'(cas_rsp_valid_o), 64'(m_rsp));
    if (m_rsp) begin
      chk(cas_old_o == m_old, {tag, " R2 old"}, cas_old_o, m_old);
      chk(cas_swapped_o == m_sw, {tag, " R2 swapped"}, 64'(cas_swapped_o), 64'(m_sw));
    end
    chk(stream_en_o == m_en, {tag, " R3 stream_en"}, 64'(stream_en_o), 64'(m_en));
    chk(ntf_valid_o == m_valid, {tag, " R6 ntf_valid"}, 64'(ntf_valid_o), 64'(m_valid));
    if (m_valid) begin
      chk(ntf_data_o == m_data, {tag, " R9 ntf_data"}, 64'(ntf_data_o), 64'(m_data));
      chk(ntf_addr_o == m_addr, {tag, " R6 ntf_addr"}, ntf_addr_o, m_addr);
    end
    bus_reset_i = br; cas_valid_i = cv; cas_cmp_i = cmp; cas_new_i = nw;
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd; rd_addr_i = ra;
    evt_i = ev; ntf_ready_i = rdy;
    #1;
    chk(rd_data_o == exp_read(ra), {tag, " R11 rd_data"}, 64'(rd_data_o), 64'(exp_read(ra)));
    chk(cas_ready_o == !br, {tag, " R4 cas_ready"}, 64'(cas_ready_o), 64'(!br));
    // advance the reference
    own_now = m_owner;
    fire = cv && !br;
    m_rsp = fire;
    if (fire) begin m_old = own_now; m_sw = (own_now == cmp); end
    if (br) m_owner = OWNER_NONE;
    else if (fire && own_now == cmp) m_owner = nw;
    if (br) m_en = 1'b0;
    else if (we && wa == 2'd3) m_en = |wd;
    if (|ev) m_note = ev;
    free = !m_valid || rdy;
    if (free) begin
      cand = m_pend | ev;
      m_pend = '0;
      if ((|cand) && own_now != OWNER_NONE) begin
        m_valid = 1'b1; m_data = cand; m_addr = own_now;
      end else m_valid = 1'b0;
    end else m_pend = m_pend | ev;
  endtask

  task automatic idle(input string tag, input logic [1:0] ra);
    step(tag, 0, 0, '0, '0, 0, 2'd0, '0, ra, '0, 1'b1);
  endtask

  localparam logic [63:0] OWN_A = 64'h0001_0000_0000_1000;
  localparam logic [63:0] OWN_B = 64'h0023_0000_ABCD_0040;

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    #1;
    chk(ntf_valid_o == 1'b0, "R1 ntf_valid", 64'(ntf_valid_o), 64'd0);
    chk(stream_en_o == 1'b0, "R1 stream_en", 64'(stream_en_o), 64'd0);
    chk(cas_rsp_valid_o == 1'b0, "R1 rsp_valid", 64'(cas_rsp_valid_o), 64'd0);
    idle("R1", 2'd0); idle("R1", 2'd1); idle("R1", 2'd2); idle("R1", 2'd3);
    // R7 events without owner are not sent
    step("R7", 0, 0, '0, '0, 0, 2'd0, '0, 2'd2, 32'h1 << EVB_RXCFG, 1'b1);
    idle("R7", 2'd2);
    chk(ntf_valid_o == 1'b0, "R7 no request without owner", 64'(ntf_valid_o), 64'd0);
    // R3 plain writes rejected except enable
    step("R3", 0, 0, '0, '0, 1, 2'd0, 32'h1234_5678, 2'd0, '0, 1'b1);
    step("R3", 0, 0, '0, '0, 1, 2'd1, 32'h9ABC_DEF0, 2'd0, '0, 1'b1);
    step("R3", 0, 0, '0, '0, 1, 2'd2, 32'h0000_00FF, 2'd1, '0, 1'b1);
    step("R3", 0, 0, '0, '0, 1, 2'd3, 32'h0000_0100, 2'd2, '0, 1'b1);
    idle("R3", 2'd3);
    chk(rd_data_o == 32'h1, "R3 enable word", 64'(rd_data_o), 64'd1);
    // R2 failing then succeeding compare-and-swap
    step("R2", 0, 1, OWN_B, OWN_A, 0, 2'd0, '0, 2'd0, '0, 1'b1);
    step("R2", 0, 1, OWNER_NONE, OWN_A, 0, 2'd0, '0, 2'd0, '0, 1'b1);
    idle("R2", 2'd0);
    chk(cas_swapped_o == 1'b1, "R2 swap taken", 64'(cas_swapped_o), 64'd1);
    idle("R2", 2'd1);
    // R5 R6 R10 event batch with back-pressure
    step("R10", 0, 0, '0, '0, 0, 2'd0, '0, 2'd2,
         (32'h1 << EVB_LOCK) | (32'h1 << EVB_CLKACC), 1'b0);
    step("R5", 0, 0, '0, '0, 0, 2'd0, '0, 2'd2, 32'h1 << EVB_TXCFG, 1'b0);
    chk(ntf_data_o == 32'h30, "R6 launched data", 64'(ntf_data_o), 64'h30);
    // R8 stall, R9 accumulate
    step("R8", 0, 0, '0, '0, 0, 2'd0, '0, 2'd2, 32'h8000_0000, 1'b0);
    step("R9", 0, 0, '0, '0, 0, 2'd0, '0, 2'd2, 32'h1 << EVB_EXTST, 1'b1);
    idle("R9", 2'd2);
    chk(m_data == 32'h8000_0042, "R9 merged pending", 64'(m_data), 64'h8000_0042);
    idle("R9", 2'd2);
    // R4 bus reset beats a matching compare-and-swap
    step("R4", 1, 1, OWN_A, OWN_B, 1, 2'd3, 32'h1, 2'd0, '0, 1'b1);
    idle("R4", 2'd0);
    chk(cas_rsp_valid_o == 1'b0, "R4 no response", 64'(cas_rsp_valid_o), 64'd0);
    chk(rd_data_o == 32'hFFFF_0000, "R4 owner cleared", 64'(rd_data_o), 64'hFFFF_0000);
    idle("R4", 2'd3);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit br, cv, we, rdy;
      logic [63:0] cmp, nw;
      logic [31:0] ev;
      br  = ($urandom_range(63) == 0);
      cv  = ($urandom_range(7) == 0);
      cmp = ($urandom_range(1) == 0) ? m_owner : ($urandom_range(1) ? OWNER_NONE : OWN_B);
      case ($urandom_range(3))
        0: nw = OWNER_NONE;
        1: nw = OWN_A;
        2: nw = OWN_B;
        default: nw = {$urandom(), $urandom()};
      endcase
      we  = ($urandom_range(5) == 0);
      rdy = $urandom_range(1);
      r   = $urandom();
      ev  = ($urandom_range(2) == 0) ? (r & $urandom() & $urandom()) : 32'h0;
      step("RND", br, cv, cmp, nw, we, 2'($urandom_range(3)), $urandom_range(1) ? 32'h0 : $urandom(),
           2'($urandom_range(3)), ev, rdy);
    end
    idle("END", 2'd2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule